// File: doc/BRIEF.md
# Reset Source Status Controller

This block merges the reset causes of a small microcontroller into one internal reset and keeps a status byte that records which cause came last. There are four causes. Two are power-on detects: an ordinary one and a cold one, which means the supply was fully absent. The other two are an active-high external reset pin and a one-cycle watchdog timeout pulse. The external pin passes through a synchronizer before it is merged. The internal reset is a registered level, so it both rises and releases on a clock edge. While it is high, a flag tells the pad logic to turn the two quasi-bidirectional strobe pins (address latch enable and program store enable) into inputs.

Software reaches the block through a two-address register bus. Address 0 is the status byte. Address 1 is the unlock register. The power-on flag and the watchdog-enable bit are guarded. They change only when a write lands in a short unlock window, which two key bytes written in order will open. The watchdog-reset flag is read-only and clears when it is read. The remaining bits of the byte are ordinary read/write storage.

Top module: `rstStatusCtl`

## Requirements
- R1: `intRst` goes high one clock after any of `porReq`, `coldPorReq` or `wdtTimeout` is sampled high. It stays high while any cause is present and falls one clock after the last cause is gone.
- R2: `extRstPin` passes through two flops before it is merged. A level change that is first sampled at edge n shows on `intRst` after edge n+2, both when the pin rises and when it falls.
- R3: `strobeForceInput` is high in exactly the cycles in which `intRst` is high.
- R4: A read of address 0 returns the status byte in the same cycle. Bit 6 is the power-on flag, bit 4 is the watchdog-reset flag and bit 2 is the watchdog-enable bit. The other bits hold plain storage, limited to the bits set in `PLAIN_MASK` (default 0xAB). A read of address 1, or no read at all, returns 0.
- R5: The power-on flag (`porFlag`) is cleared by `porReq` or `coldPorReq`. An external or watchdog reset leaves it unchanged.
- R6: The watchdog-reset flag (`wdtResetFlag`) is set by `wdtTimeout`. No other kind of reset changes it, and a write to the status byte never changes it.
- R7: A read of address 0 clears the watchdog-reset flag at the end of the read cycle. If a timeout falls in the same cycle, the flag stays set.
- R8: The watchdog-enable bit drives `wdtEnable`. Only `coldPorReq` clears it.
- R9: Writing 0xAA and then 0x55 to address 1, with no other write between them, opens an unlock window for 4 clock cycles. A status write inside the window also updates bits 6 and 2, and that write closes the window.
- R10: Any write that breaks the key sequence closes the window or the partial sequence. This covers a wrong second byte, a status write between the two key bytes, and a write to address 1 while the window is open. Outside the window, a status write leaves bits 6 and 2 unchanged but still updates the plain bits.
- R11: While `intRst` is high, the plain bits are cleared and every bus access is ignored: writes change nothing, a read returns 0 and a read does not clear the watchdog-reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-on detect, active high |
| coldPorReq | input | 1 | Power-on detect after a total supply loss, active high |
| extRstPin | input | 1 | External reset pin, asynchronous, active high |
| wdtTimeout | input | 1 | Watchdog timeout pulse |
| busAddr | input | 1 | Register select: 0 status byte, 1 unlock register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| intRst | output | 1 | Merged internal reset |
| strobeForceInput | output | 1 | Forces the two strobe pins to inputs |
| porFlag | output | 1 | Power-on flag (status bit 6) |
| wdtResetFlag | output | 1 | Watchdog-reset flag (status bit 4) |
| wdtEnable | output | 1 | Watchdog enable (status bit 2) |

## Verification
Two things can hit the watchdog-reset flag in the same cycle: the clear that a status read causes and the set that a new timeout pulse causes. The bench first sets the flag with a timeout. It then drives a status read and a fresh timeout in the same cycle and checks that the flag still reads 1 after that edge, and that a later read on its own clears it. In the same spirit, the bench places a guarded write at each cycle offset after the key pair and tries every possible second key byte, comparing each case against an arithmetic window model.

// File: rtl/rstStatusPkg.sv
package rstStatusPkg;

  localparam logic       ADDR_STATUS = 1'b0;
  localparam logic       ADDR_UNLOCK = 1'b1;
  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;

  // Bit positions that software decodes
  localparam int POR_BIT = 6;
  localparam int WDR_BIT = 4;
  localparam int EWT_BIT = 2;
  localparam logic [7:0] SPECIAL_BITS = (8'h1 << POR_BIT) | (8'h1 << WDR_BIT) | (8'h1 << EWT_BIT);

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_FIRST = 2'd1,
    TA_OPEN  = 2'd2
  } taState_e;

  typedef struct packed {
    logic anyReset;   // registered internal reset
    logic porClear;   // any power-on cause
    logic coldClear;  // cold power-on cause
    logic wdtSet;     // watchdog timeout event
    logic wrStatus;   // accepted status write
    logic wrGuarded;  // status write inside unlock window
    logic rdStatus;   // accepted status read
  } ctlStrobes_t;

endpackage

// File: rtl/rstStatusSync.sv
module rstStatusSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) chain <= asyncIn;
    end else begin : gChain
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rstStatusCtrl.sv
module rstStatusCtrl
  import rstStatusPkg::*;
#(
  parameter int WINDOW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        porReq,
  input  logic        coldPorReq,
  input  logic        extRstPin,
  input  logic        wdtTimeout,
  input  logic        busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  output logic        intRst,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic       extSync;
  logic       anyCause;
  taState_e   taState, taNext;
  logic [CNT_W-1:0] winCnt, winNext;
  logic       anyWr, keyWr, stWr, stRd;

  rstStatusSync #(.STAGES(SYNC_STAGES)) u_extSync (
    .clk     (clk),
    .asyncIn (extRstPin),
    .syncOut (extSync)
  );

  assign anyCause = porReq | coldPorReq | wdtTimeout | extSync;

  always_ff @(posedge clk) intRst <= anyCause;

  assign anyWr = busWr & ~intRst;
  assign keyWr = anyWr & (busAddr == ADDR_UNLOCK);
  assign stWr  = anyWr & (busAddr == ADDR_STATUS);
  assign stRd  = busRd & ~intRst & (busAddr == ADDR_STATUS);

  always_comb begin
    taNext  = taState;
    winNext = winCnt;
    unique case (taState)
      TA_IDLE: begin
        if (keyWr && busWdata == KEY_FIRST) taNext = TA_FIRST;
      end
      TA_FIRST: begin
        if (anyWr) begin
          if (keyWr && busWdata == KEY_SECOND) begin
            taNext  = TA_OPEN;
            winNext = CNT_W'(WINDOW);
          end else if (keyWr && busWdata == KEY_FIRST) begin
            taNext = TA_FIRST;
          end else begin
            taNext = TA_IDLE;
          end
        end
      end
      TA_OPEN: begin
        if (anyWr) begin
          taNext  = (keyWr && busWdata == KEY_FIRST) ? TA_FIRST : TA_IDLE;
          winNext = '0;
        end else if (winCnt <= CNT_W'(1)) begin
          taNext  = TA_IDLE;
          winNext = '0;
        end else begin
          winNext = winCnt - CNT_W'(1);
        end
      end
      default: begin
        taNext  = TA_IDLE;
        winNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (intRst) begin
      taState <= TA_IDLE;
      winCnt  <= '0;
    end else begin
      taState <= taNext;
      winCnt  <= winNext;
    end
  end

  always_comb begin
    strobes.anyReset  = intRst;
    strobes.porClear  = porReq | coldPorReq;
    strobes.coldClear = coldPorReq;
    strobes.wdtSet    = wdtTimeout;
    strobes.wrStatus  = stWr;
    strobes.wrGuarded = stWr & (taState == TA_OPEN);
    strobes.rdStatus  = stRd;
  end
endmodule

// File: rtl/rstStatusData.sv
module rstStatusData
  import rstStatusPkg::*;
#(
  parameter logic [7:0] PLAIN_MASK = 8'hAB
) (
  input  logic        clk,
  input  ctlStrobes_t strobes,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        porFlag,
  output logic        wdrFlag,
  output logic        ewtFlag
);
  localparam logic [7:0] EFF_MASK = PLAIN_MASK & ~SPECIAL_BITS;

  logic [7:0] plainBits;
  logic [7:0] statusByte;

  // Power-on flag: cleared by power-on, written only when unlocked
  always_ff @(posedge clk) begin
    if (strobes.porClear)       porFlag <= 1'b0;
    else if (strobes.wrGuarded) porFlag <= busWdata[POR_BIT];
  end

  // Watchdog-reset flag: set wins over clear-on-read
  always_ff @(posedge clk) begin
    if (strobes.wdtSet)        wdrFlag <= 1'b1;
    else if (strobes.rdStatus) wdrFlag <= 1'b0;
  end

  // Watchdog enable: cleared only by cold power-on
  always_ff @(posedge clk) begin
    if (strobes.coldClear)      ewtFlag <= 1'b0;
    else if (strobes.wrGuarded) ewtFlag <= busWdata[EWT_BIT];
  end

  always_ff @(posedge clk) begin
    if (strobes.anyReset)      plainBits <= '0;
    else if (strobes.wrStatus) plainBits <= busWdata & EFF_MASK;
  end

  always_comb begin
    statusByte          = plainBits & EFF_MASK;
    statusByte[POR_BIT] = porFlag;
    statusByte[WDR_BIT] = wdrFlag;
    statusByte[EWT_BIT] = ewtFlag;
  end

  assign busRdata = strobes.rdStatus ? statusByte : 8'h00;
endmodule

// File: rtl/rstStatusCtl.sv
module rstStatusCtl
  import rstStatusPkg::*;
#(
  parameter int         WINDOW      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PLAIN_MASK  = 8'hAB
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       coldPorReq,
  input  logic       extRstPin,
  input  logic       wdtTimeout,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       intRst,
  output logic       strobeForceInput,
  output logic       porFlag,
  output logic       wdtResetFlag,
  output logic       wdtEnable
);
  ctlStrobes_t strobes;

  rstStatusCtrl #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .porReq     (porReq),
    .coldPorReq (coldPorReq),
    .extRstPin  (extRstPin),
    .wdtTimeout (wdtTimeout),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWdata   (busWdata),
    .intRst     (intRst),
    .strobes    (strobes)
  );

  rstStatusData #(.PLAIN_MASK(PLAIN_MASK)) u_data (
    .clk      (clk),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .porFlag  (porFlag),
    .wdrFlag  (wdtResetFlag),
    .ewtFlag  (wdtEnable)
  );

  assign strobeForceInput = intRst;
endmodule

// File: rtl/rstStatusChk.sv
module rstStatusChk (
  input logic       clk,
  input logic       porReq,
  input logic       coldPorReq,
  input logic       extRstPin,
  input logic       wdtTimeout,
  input logic       busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic       intRst,
  input logic       porFlag,
  input logic       wdtResetFlag,
  input logic       wdtEnable
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | coldPorReq;

  assert_cause_raises_R1: assert property (@(posedge clk) disable iff (!armed)
    (porReq || coldPorReq || wdtTimeout) |=> intRst);

  assert_pin_held_R2: assert property (@(posedge clk) disable iff (!armed)
    (extRstPin && $past(extRstPin) && $past(extRstPin, 2)) |=> intRst);

  assert_por_clear_R5: assert property (@(posedge clk) disable iff (!armed)
    (porReq || coldPorReq) |=> !porFlag);

  assert_wdt_set_R6: assert property (@(posedge clk) disable iff (!armed)
    wdtTimeout |=> wdtResetFlag);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!armed)
    $fell(wdtResetFlag) |-> $past(busRd && busAddr == 1'b0 && !intRst));

  assert_cold_clear_R8: assert property (@(posedge clk) disable iff (!armed)
    coldPorReq |=> !wdtEnable);

  assert_ewt_guard_R9: assert property (@(posedge clk) disable iff (!armed)
    $rose(wdtEnable) |-> $past(busWr && busAddr == 1'b0 && !intRst));

  assert_por_guard_R10: assert property (@(posedge clk) disable iff (!armed)
    $rose(porFlag) |-> $past(busWr && busAddr == 1'b0 && !intRst));
endmodule

bind rstStatusCtl rstStatusChk u_chk (
  .clk          (clk),
  .porReq       (porReq),
  .coldPorReq   (coldPorReq),
  .extRstPin    (extRstPin),
  .wdtTimeout   (wdtTimeout),
  .busAddr      (busAddr),
  .busWr        (busWr),
  .busRd        (busRd),
  .intRst       (intRst),
  .porFlag      (porFlag),
  .wdtResetFlag (wdtResetFlag),
  .wdtEnable    (wdtEnable)
);

// File: tb/rstStatusCtl_bench.sv
`timescale 1ns/1ps
module rstStatusCtl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       porReq = 1'b0, coldPorReq = 1'b1, extRstPin = 1'b0, wdtTimeout = 1'b0;
  logic       busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       intRst, strobeForceInput, porFlag, wdtResetFlag, wdtEnable;

  rstStatusCtl u_rstStatusCtl (
    .clk(clk), .porReq(porReq), .coldPorReq(coldPorReq), .extRstPin(extRstPin),
    .wdtTimeout(wdtTimeout), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .intRst(intRst),
    .strobeForceInput(strobeForceInput), .porFlag(porFlag),
    .wdtResetFlag(wdtResetFlag), .wdtEnable(wdtEnable)
  );

  localparam logic [7:0] PLAIN = 8'hAB;
  int checks = 0, fails = 0;
  logic expPor, expWdr, expEwt;
  logic [7:0] expPlain;

  function automatic logic [7:0] expByte();
    return (expPlain & PLAIN) | ({7'd0, expPor} << 6) | ({7'd0, expWdr} << 4) | ({7'd0, expEwt} << 2);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick();
    busWr = 1'b0;
  endtask

  task automatic readStatus(input string req);
    busAddr = 1'b0; busRd = 1'b1;
    #1 check(req, busRdata, expByte());
    tick();
    busRd = 1'b0;
    expWdr = 1'b0;
  endtask

  task automatic checkFlags(input string req);
    check({req, " por"}, {7'd0, porFlag}, {7'd0, expPor});
    check({req, " wdr"}, {7'd0, wdtResetFlag}, {7'd0, expWdr});
    check({req, " ewt"}, {7'd0, wdtEnable}, {7'd0, expEwt});
  endtask

  // guarded write of the inverted protected bits plus plain data
  task automatic guardedToggle(input logic [7:0] plainData, input logic accept, input string req);
    logic [7:0] w;
    w = (plainData & PLAIN) | ({7'd0, ~expPor} << 6) | ({7'd0, ~expEwt} << 2);
    busWrite(1'b0, w);
    expPlain = w & PLAIN;
    if (accept) begin expPor = ~expPor; expEwt = ~expEwt; end
    checkFlags(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    // reset state under cold power-on
    check("R1 cold reset active", {7'd0, intRst}, 8'd1);
    check("R3 strobes forced", {7'd0, strobeForceInput}, 8'd1);
    check("R5 por cleared", {7'd0, porFlag}, 8'd0);
    check("R8 ewt cleared", {7'd0, wdtEnable}, 8'd0);
    coldPorReq = 1'b0;
    tick();
    check("R1 release after cause gone", {7'd0, intRst}, 8'd0);
    check("R3 strobes released", {7'd0, strobeForceInput}, 8'd0);
    expPor = 0; expEwt = 0; expPlain = 0; expWdr = wdtResetFlag;
    readStatus("R4 first read");
    check("R7 cleared by read", {7'd0, wdtResetFlag}, 8'd0);
    busAddr = 1'b1; busRd = 1'b1;
    #1 check("R4 unlock address reads zero", busRdata, 8'h00);
    tick(); busRd = 1'b0;
    #1 check("R4 idle read data zero", busRdata, 8'h00);

    // sweep all values without unlock: plain update only
    for (int v = 0; v < 256; v++) begin
      busWrite(1'b0, 8'(v));
      expPlain = 8'(v) & PLAIN;
      readStatus("R10 unguarded write sweep");
    end

    // sweep second key byte
    for (int b = 0; b < 256; b++) begin
      busWrite(1'b1, 8'hAA);
      busWrite(1'b1, 8'(b));
      guardedToggle(8'(b), b == 8'h55, (b == 8'h55) ? "R9 correct key" : "R10 wrong second key");
    end

    // window length sweep
    for (int d = 0; d < 7; d++) begin
      busWrite(1'b1, 8'hAA);
      busWrite(1'b1, 8'h55);
      repeat (d) tick();
      guardedToggle(8'(d), d <= 3, "R9 window length");
    end

    // window closes after one guarded write
    busWrite(1'b1, 8'hAA); busWrite(1'b1, 8'h55);
    guardedToggle(8'h01, 1'b1, "R9 first guarded write");
    guardedToggle(8'h02, 1'b0, "R9 second write after close");

    // status write between key bytes
    busWrite(1'b1, 8'hAA);
    busWrite(1'b0, 8'h03); expPlain = 8'h03 & PLAIN;
    busWrite(1'b1, 8'h55);
    guardedToggle(8'h08, 1'b0, "R10 interrupted sequence");

    // unlock write while open closes window
    busWrite(1'b1, 8'hAA); busWrite(1'b1, 8'h55); busWrite(1'b1, 8'h00);
    guardedToggle(8'h20, 1'b0, "R10 unlock write closes window");

    // ensure ewt and por are 1 for reset-keep checks
    if (!expEwt) begin
      busWrite(1'b1, 8'hAA); busWrite(1'b1, 8'h55);
      guardedToggle(8'h00, 1'b1, "R9 set flags");
    end
    readStatus("R4 flags set readback");

    // watchdog timeout
    wdtTimeout = 1'b1; tick(); wdtTimeout = 1'b0;
    expWdr = 1'b1;
    check("R1 watchdog reset", {7'd0, intRst}, 8'd1);
    check("R6 wdr set", {7'd0, wdtResetFlag}, 8'd1);
    tick();
    check("R1 watchdog reset one cycle", {7'd0, intRst}, 8'd0);
    expPlain = 0;
    checkFlags("R5 R8 kept over watchdog");
    readStatus("R11 plain cleared by reset");
    check("R7 read clears wdr", {7'd0, wdtResetFlag}, 8'd0);

    // same-cycle read and timeout
    wdtTimeout = 1'b1; tick(); wdtTimeout = 1'b0; tick();
    expWdr = 1'b1;
    busAddr = 1'b0; busRd = 1'b1; wdtTimeout = 1'b1;
    #1 check("R7 read during set", busRdata, expByte());
    tick(); busRd = 1'b0; wdtTimeout = 1'b0;
    check("R7 set wins over clear", {7'd0, wdtResetFlag}, 8'd1);
    tick();
    readStatus("R7 later read");
    check("R7 later read clears", {7'd0, wdtResetFlag}, 8'd0);

    // external pin and bus ignored during reset
    wdtTimeout = 1'b1; tick(); wdtTimeout = 1'b0; tick(); expWdr = 1'b1;
    extRstPin = 1'b1;
    tick(); check("R2 not yet after 1 edge", {7'd0, intRst}, 8'd0);
    tick(); check("R2 not yet after 2 edges", {7'd0, intRst}, 8'd0);
    tick(); check("R2 asserted after 3 edges", {7'd0, intRst}, 8'd1);
    check("R3 strobes forced ext", {7'd0, strobeForceInput}, 8'd1);
    busAddr = 1'b0; busRd = 1'b1;
    #1 check("R11 read during reset", busRdata, 8'h00);
    tick(); busRd = 1'b0;
    busWrite(1'b0, 8'hFF);
    extRstPin = 1'b0;
    tick(); check("R2 still held 1", {7'd0, intRst}, 8'd1);
    tick(); check("R2 still held 2", {7'd0, intRst}, 8'd1);
    tick(); check("R2 released", {7'd0, intRst}, 8'd0);
    expPlain = 0;
    checkFlags("R6 R11 kept over external reset");
    readStatus("R11 write during reset ignored");

    // ordinary power-on
    porReq = 1'b1; tick();
    check("R1 por reset", {7'd0, intRst}, 8'd1);
    tick(); porReq = 1'b0; tick();
    check("R1 por release", {7'd0, intRst}, 8'd0);
    expPor = 0;
    checkFlags("R5 por clears only por flag");

    // cold power-on
    coldPorReq = 1'b1; tick(); tick(); coldPorReq = 1'b0; tick();
    expPor = 0; expEwt = 0;
    checkFlags("R8 cold clears ewt");
    readStatus("R4 final readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule